// File: doc/BRIEF.md
# Serial Audio Slot Transmitter

This block turns parallel audio words into a time-division serial stream. Each frame holds `SLOTS` slots of `SLOT_W` bit clocks, and each slot carries one `WORD_W`-bit word, most significant bit first. The block drives the bit clock itself at half the system clock rate. Data and frame sync change on the falling edge of the bit clock, so a receiver samples them on the rising edge.

When a word is shorter than its slot, `right_align` picks where the word sits in the slot. `zero_pad` picks the fill for the spare bits: zeros, or a copy of the word's nearest edge bit. A frame sync pulse one word long marks the word in slot 0. `fs_early` moves that pulse one bit clock ahead of the word.

Words arrive on a valid/ready handshake, one per slot. If no word is offered, the previous word goes out again and a sticky underrun flag is raised. The `tx_rst` input is a local reset for the transmitter. It stops the serializer at once, releases the data line, forces the clock and sync outputs low and clears the underrun flag. The control inputs are left as they are.

Top module: `serial_slot_tx`

## Requirements
- R1: The word is sent MSB first. Left-aligned (`right_align`=0), it fills slot positions 0..WORD_W-1. Right-aligned (`right_align`=1), it fills positions SLOT_W-WORD_W..SLOT_W-1. Position 0 is the first bit clock of the slot.
- R2: Left-aligned with `zero_pad`=0, every position after the word repeats the word's LSB.
- R3: Left-aligned with `zero_pad`=1, every position after the word is 0.
- R4: Right-aligned with `zero_pad`=0, every position before the word repeats the word's MSB.
- R5: Right-aligned with `zero_pad`=1, every position before the word is 0.
- R6: With `fs_early`=0, `fsync` is high for exactly the WORD_W bit clocks that carry the word of slot 0, and is low in all other slots.
- R7: With `fs_early`=1, the `fsync` pulse keeps its length but starts and ends one bit clock earlier. For a left-aligned word it therefore covers the last bit of the last slot of the previous frame.
- R8: `bclk` toggles every system clock cycle. `sdo` and `fsync` change only in the cycle in which `bclk` falls.
- R9: `wready` is high for one system clock per slot, during the high phase of the slot's last bit. A word accepted then is sent in the next slot.
- R10: If `wvalid` is low when `wready` is high, the next slot repeats the previous word and `underrun` is set. It stays set until `tx_rst` is asserted.
- R11: While `tx_rst` is high, `sdo_en`, `sdo`, `bclk`, `fsync` and `wready` are 0 in the same cycle, and `underrun` clears at the next clock edge. After release, the serializer inserts one lead-in bit and then starts a frame at slot 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_rst | input | 1 | Transmitter local reset, active high |
| fs_early | input | 1 | Start frame sync one bit clock before the word |
| right_align | input | 1 | Place the word at the end of the slot |
| zero_pad | input | 1 | Fill spare slot bits with zeros |
| wdata | input | WORD_W | Parallel word to send |
| wvalid | input | 1 | `wdata` holds a word |
| wready | output | 1 | Word accepted at this clock edge if `wvalid` is high |
| sdo | output | 1 | Serial data |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means tri-state |
| fsync | output | 1 | Word-length frame sync |
| bclk | output | 1 | Bit clock |
| underrun | output | 1 | Sticky flag: a slot started with no new word |

## Verification
The bound assertions check four things on every cycle. The frame sync pulse must last exactly WORD_W bit clocks. Data and sync must hold while the bit clock is low or rising. The ready strobe must appear only in the bit clock's high phase. The local reset must silence the outputs and keep the underrun flag sticky until it clears it. The bench scenarios show what those per-cycle properties cannot: the exact bit stream for each alignment and padding combination, where the sync pulse sits in each timing mode, the repeated word after an underrun, and the restart position after a local reset.

// File: rtl/serial_slot_tx.sv
module serial_slot_tx #(
  parameter int WORD_W = 8,
  parameter int SLOT_W = 12,
  parameter int SLOTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_rst,
  input  logic              fs_early,
  input  logic              right_align,
  input  logic              zero_pad,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic              sdo,
  output logic              sdo_en,
  output logic              fsync,
  output logic              bclk,
  output logic              underrun
);
  localparam int PAD = SLOT_W - WORD_W;
  localparam int PW  = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
  localparam int SW  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int WW  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [PW-1:0] POS_LAST  = PW'(SLOT_W - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic              ph;
  logic [PW-1:0]     pos, pos_nx;
  logic [SW-1:0]     slot, slot_nx;
  logic [WORD_W-1:0] word;
  logic              urun;
  logic              sbit, fs_raw;

  wire last_pos = (pos == POS_LAST);
  wire step     = ph & ~tx_rst;

  assign pos_nx  = last_pos ? '0 : pos + PW'(1);
  assign slot_nx = !last_pos ? slot : ((slot == SLOT_LAST) ? '0 : slot + SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      pos  <= POS_LAST;
      slot <= SLOT_LAST;
      word <= '0;
      urun <= 1'b0;
    end else if (tx_rst) begin
      ph   <= 1'b0;
      pos  <= POS_LAST;
      slot <= SLOT_LAST;
      urun <= 1'b0;
    end else begin
      ph <= ~ph;
      if (ph) begin
        pos  <= pos_nx;
        slot <= slot_nx;
        if (last_pos) begin
          if (wvalid) word <= wdata;
          else        urun <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    int p;
    logic [WW-1:0] idx;
    p   = int'(pos);
    idx = '0;
    if (!right_align) begin
      if (p < WORD_W) begin
        idx  = WW'(WORD_W - 1 - p);
        sbit = word[idx];
      end else begin
        sbit = zero_pad ? 1'b0 : word[0];
      end
    end else begin
      if (p >= PAD) begin
        idx  = WW'(SLOT_W - 1 - p);
        sbit = word[idx];
      end else begin
        sbit = zero_pad ? 1'b0 : word[WORD_W-1];
      end
    end
  end

  always_comb begin
    int st, ps;
    logic [SW-1:0] ss;
    st     = right_align ? PAD : 0;
    ps     = fs_early ? int'(pos_nx) : int'(pos);
    ss     = fs_early ? slot_nx : slot;
    fs_raw = (ss == '0) && (ps >= st) && (ps < st + WORD_W);
  end

  assign wready   = step & last_pos;
  assign bclk     = step;
  assign sdo_en   = ~tx_rst;
  assign sdo      = sbit & ~tx_rst;
  assign fsync    = fs_raw & ~tx_rst;
  assign underrun = urun;
endmodule

// File: rtl/serial_slot_tx_chk.sv
module serial_slot_tx_chk #(
  parameter int WORD_W = 8,
  parameter int SLOT_W = 12,
  parameter int SLOTS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_rst,
  input logic              fs_early,
  input logic              right_align,
  input logic              zero_pad,
  input logic [WORD_W-1:0] wdata,
  input logic              wvalid,
  input logic              wready,
  input logic              sdo,
  input logic              sdo_en,
  input logic              fsync,
  input logic              bclk,
  input logic              underrun
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run <= '0;
    else if (tx_rst || !fsync) run <= '0;
    else                       run <= run + 16'd1;
  end

  a_r6_fsync_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fsync) && !tx_rst) |-> (run == 16'(2 * WORD_W)));

  a_r8_hold_until_fall: assert property (@(posedge clk) disable iff (!rst_n || tx_rst)
    (!$past(bclk) && !$past(tx_rst)) |-> ($stable(sdo) && $stable(fsync)));

  a_r8_bclk_toggles: assert property (@(posedge clk) disable iff (!rst_n || tx_rst)
    !$past(tx_rst) |-> (bclk != $past(bclk)));

  a_r9_ready_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wready |-> bclk);

  a_r10_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !tx_rst) |=> underrun);

  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |-> (!sdo_en && !sdo && !bclk && !fsync && !wready));

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst |=> !underrun);
endmodule

bind serial_slot_tx serial_slot_tx_chk #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS)) u_chk (.*);

// File: tb/tb_serial_slot_tx.sv
module tb_serial_slot_tx;
  localparam int WORD_W = 8;
  localparam int SLOT_W = 12;
  localparam int SLOTS  = 2;
  localparam int PAD    = SLOT_W - WORD_W;

  logic clk = 0, rst_n = 0, tx_rst = 1;
  logic fs_early = 0, right_align = 0, zero_pad = 0;
  logic [WORD_W-1:0] wdata = '0;
  logic wvalid = 0;
  logic wready, sdo, sdo_en, fsync, bclk, underrun;

  int checks = 0, errors = 0;
  int cnt = 0, feed_n = 0, idx = 0, r8_bad = 0;
  bit capture = 0, done = 0;
  logic sd_q [0:255];
  logic fs_q [0:255];
  logic en_q [0:255];
  logic prev_bclk = 0, prev_sdo = 0, prev_fs = 0;

  serial_slot_tx #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .SLOTS(SLOTS)) dut (.*);

  always #4 clk = ~clk;

  function automatic logic [WORD_W-1:0] word_of(int i);
    return WORD_W'(32'hC3 + i * 32'h29);
  endfunction

  function automatic logic exp_bit(logic [WORD_W-1:0] w, int p, bit ra, bit zp);
    logic [SLOT_W-1:0] v;
    if (!ra) v = {w, (zp ? {PAD{1'b0}} : {PAD{w[0]}})};
    else     v = {(zp ? {PAD{1'b0}} : {PAD{w[WORD_W-1]}}), w};
    return v[SLOT_W-1-p];
  endfunction

  function automatic logic exp_fs(int j, bit ra);
    int p, s, st;
    p  = j % SLOT_W;
    s  = (j / SLOT_W) % SLOTS;
    st = ra ? PAD : 0;
    return (s == 0) && (p >= st) && (p < st + WORD_W);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (capture) begin
      if (bclk && !prev_bclk && (sdo !== prev_sdo || fsync !== prev_fs)) r8_bad++;
      if (bclk === prev_bclk) r8_bad++;
      if (bclk && cnt < 256) begin
        sd_q[cnt] = sdo; fs_q[cnt] = fsync; en_q[cnt] = sdo_en;
        cnt++;
      end
    end
    prev_bclk = bclk; prev_sdo = sdo; prev_fs = fsync;
  end

  always @(negedge clk) begin
    if (capture && wvalid && wready) begin
      @(posedge clk);
      #1;
      idx++;
      if (idx < feed_n) wdata = word_of(idx);
      else wvalid = 0;
    end
  end

  task automatic start(bit ra, bit zp, bit fe, int nw, int ns);
    @(negedge clk);
    tx_rst = 1; right_align = ra; zero_pad = zp; fs_early = fe;
    feed_n = nw; idx = 0; wdata = word_of(0); wvalid = (nw > 0);
    @(negedge clk);
    cnt = 0; r8_bad = 0;
    prev_bclk = 1;
    capture = 1;
    tx_rst = 0;
    wait (cnt >= ns);
  endtask

  task automatic compare(string tag, bit ra, bit zp, bit fe, int nw, int ns);
    int bad_d = 0, bad_f = 0, bad_e = 0;
    for (int k = 0; k < ns; k++) begin
      logic ef;
      ef = fe ? exp_fs(k, ra) : ((k == 0) ? 1'b0 : exp_fs(k - 1, ra));
      if (fs_q[k] !== ef) begin
        bad_f++;
        if (bad_f == 1) $display("FAIL %s: fsync at sample %0d actual %b expected %b",
                                 fe ? "R7" : "R6", k, fs_q[k], ef);
      end
      if (en_q[k] !== 1'b1) bad_e++;
      if (k > 0) begin
        int j, g;
        logic eb;
        j  = k - 1;
        g  = j / SLOT_W;
        eb = exp_bit(word_of((g < nw) ? g : nw - 1), j % SLOT_W, ra, zp);
        if (sd_q[k] !== eb) begin
          bad_d++;
          if (bad_d == 1) $display("FAIL %s: sdo at sample %0d actual %b expected %b",
                                   tag, k, sd_q[k], eb);
        end
      end
    end
    checks += 3;
    if (bad_d) errors++;
    if (bad_f) errors++;
    if (bad_e) begin errors++; $display("FAIL R11: sdo_en low %0d times, expected 0", bad_e); end
    checks++;
    if (r8_bad) begin errors++; $display("FAIL R8: %0d bad edges actual, expected 0", r8_bad); end
  endtask

  task automatic stop();
    tx_rst = 1;
    capture = 0;
    wvalid = 0;
    @(negedge clk);
  endtask

  // R1, R2, R6: left aligned, edge repeat, normal sync
  task automatic t_left_repeat();
    int ns = 1 + 4 * SLOT_W;
    start(0, 0, 0, 4, ns);
    check("R10 no underrun with full feed", underrun, 1'b0);
    stop();
    compare("R1/R2 left repeat", 0, 0, 0, 4, ns);
  endtask

  // R1, R3
  task automatic t_left_zero();
    int ns = 1 + 4 * SLOT_W;
    start(0, 1, 0, 4, ns);
    stop();
    compare("R3 left zero", 0, 1, 0, 4, ns);
  endtask

  // R4, R6 right aligned sync position
  task automatic t_right_repeat();
    int ns = 1 + 4 * SLOT_W;
    start(1, 0, 0, 4, ns);
    stop();
    compare("R4 right repeat", 1, 0, 0, 4, ns);
  endtask

  // R5, R7
  task automatic t_right_zero_early();
    int ns = 1 + 4 * SLOT_W;
    start(1, 1, 1, 4, ns);
    stop();
    compare("R5 right zero", 1, 1, 1, 4, ns);
  endtask

  // R7: early sync covers the lead-in bit
  task automatic t_left_early();
    int ns = 1 + 4 * SLOT_W;
    start(0, 0, 1, 4, ns);
    stop();
    compare("R1 left early", 0, 0, 1, 4, ns);
    check("R7 early sync on lead-in bit", fs_q[0], 1'b1);
    check("R7 early sync on last bit of previous frame", fs_q[2 * SLOT_W], 1'b1);
  endtask

  // R9, R10, R11
  task automatic t_underrun_reset();
    int ns = 1 + 2 * SLOT_W + 3;
    int hs = 0;
    start(0, 1, 0, 1, ns);
    check("R10 underrun set", underrun, 1'b1);
    check("R6 sync high in slot 0 before reset", fsync, 1'b1);
    capture = 0;
    compare("R10 repeat word", 0, 1, 0, 1, ns);
    tx_rst = 1;
    #1;
    check("R11 sdo_en low", sdo_en, 1'b0);
    check("R11 bclk low", bclk, 1'b0);
    check("R11 fsync low", fsync, 1'b0);
    check("R11 sdo low", sdo, 1'b0);
    check("R11 wready low", wready, 1'b0);
    @(negedge clk);
    check("R11 underrun cleared", underrun, 1'b0);
    tx_rst = 0;
    for (int c = 0; c < 4 * SLOT_W; c++) begin
      @(negedge clk);
      if (wready) begin
        hs++;
        check("R9 wready in bclk high phase", bclk, 1'b1);
      end
    end
    checks++;
    if (hs != 2) begin errors++; $display("FAIL R9: handshakes actual %0d expected 2", hs); end
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset sdo_en", sdo_en, 1'b0);
    check("R11 reset bclk", bclk, 1'b0);
    check("R11 reset underrun", underrun, 1'b0);
    t_left_repeat();
    t_left_zero();
    t_right_repeat();
    t_right_zero_early();
    t_left_early();
    t_underrun_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule